// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare and Aliased Control Registers

This block is the register-facing core of a real-time clock. It keeps a 32-bit seconds count that advances once for each single-cycle pulse on a one-second strobe input. It compares that count against a software-loaded alarm value and raises a level interrupt when they meet. Two domains gate the alarm. A persistent-domain enable decides whether a match is recorded at all. A control-register enable decides whether a recorded match drives the interrupt pin.

Software reaches the block over a simple 32-bit word bus with a write strobe and a combinational read port. Each bit-field register has three write addresses. The base address replaces the value, base+0x4 ORs the data in, and base+0x8 clears every bit that is 1 in the data. Single bits can therefore be changed without a read-modify-write. A read-only status word reports that the clock is present and which crystal strap inputs are tied high. The seconds, alarm and watchdog-timeout words are plain storage and take writes only at their base address.

Top module: `rtc_alarm_regs`

## Requirements
- R1: After reset every stored register reads 0, the seconds count is 0 and `alarmIrq` is 0.
- R2: Any word at 0x10..0x1C reads bit 31 = 1, bit 28 = `strapXtal32000`, bit 27 = `strapXtal32768` and 0 elsewhere. Writes there change nothing.
- R3: The seconds word at 0x30 increments by one on each clock with `secTick` high and wraps from 0xFFFFFFFF to 0. A base write loads it, and that write wins over a tick in the same cycle.
- R4: For the control (0x00), persistent-0 (0x60) and persistent-1 (0x70) words, a write at base replaces the value, base+0x4 ORs the data in, and base+0x8 clears the bits set in the data. A read at base, +0x4, +0x8 or +0xC returns the current value.
- R5: Only implemented bits hold a 1. In the control word these are 0 (alarm interrupt enable), 1 (millisecond interrupt enable), 2 (alarm flag) and 4 (watchdog enable). In persistent-0 they are bits 0, 1 (wake enable), 2 (alarm enable), 4, 5, 6 and 7 (wake flag). In persistent-1 only bit 31 is implemented.
- R6: On a tick where persistent-0 bit 2 is 1 and the seconds count before the tick equals the alarm word (0x40), control bit 2 reads 1 from the next cycle. With persistent-0 bit 2 at 0, no flag is set.
- R7: On the same match, if persistent-0 bit 1 is 1, persistent-0 bit 7 is also set.
- R8: `alarmIrq` is 1 exactly when control bit 2 and control bit 0 are both 1.
- R9: If a match sets the flag in the same cycle that software clears or rewrites the control word, the flag ends at 1. The same holds for the wake flag against a persistent-0 write.
- R10: The following writes are ignored: writes at +0xC of any word, writes at +0x4/+0x8/+0xC of the seconds, alarm and watchdog words (0x50), writes with address bits [1:0] nonzero, and writes to unmapped addresses (0x20..0x2C, 0x80 and up). Reads of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte address of the word accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| secTick | input | 1 | One-second strobe, one cycle wide |
| strapXtal32000 | input | 1 | Strap: 32000 Hz crystal fitted |
| strapXtal32768 | input | 1 | Strap: 32768 Hz crystal fitted |
| alarmIrq | output | 1 | Alarm interrupt, level |

## Verification
A wrong seconds or alarm value stays hidden at the interrupt pin until the next tick that should or should not match. The bench therefore reads back each word in the cycle after it is written, and it places ticks right at the match points. A flag that is set wrongly, or not set, shows on `alarmIrq` and on the control readback one cycle after the tick. An alias that is decoded wrongly is caught by reading the affected word immediately. The read port is combinational, so each stored bit can be seen in the cycle after the edge that changed it.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

  localparam int DATA_W = 32;

  // bit positions the datapath and the interrupt path depend on
  localparam int CTRL_IRQ_EN   = 0;
  localparam int CTRL_FLAG     = 2;
  localparam int P0_WAKE_EN    = 1;
  localparam int P0_ALARM_EN   = 2;
  localparam int P0_WAKE_FLAG  = 7;
  localparam int STAT_PRESENT  = 31;
  localparam int STAT_X32000   = 28;
  localparam int STAT_X32768   = 27;

  localparam logic [DATA_W-1:0] CTRL_MASK  = 32'h0000_0017;
  localparam logic [DATA_W-1:0] PERS0_MASK = 32'h0000_00F7;
  localparam logic [DATA_W-1:0] PERS1_MASK = 32'h8000_0000;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2
  } aliasOp_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_SEC,
    SEL_ALARM, SEL_WDOG, SEL_PERS0, SEL_PERS1
  } rdSel_e;

  typedef struct packed {
    logic     wrCtrl;
    logic     wrPers0;
    logic     wrPers1;
    logic     wrSec;
    logic     wrAlarm;
    logic     wrWdog;
    aliasOp_e op;
  } regStrobes_t;

  function automatic logic [DATA_W-1:0] applyAlias(
    input logic [DATA_W-1:0] oldVal,
    input logic [DATA_W-1:0] data,
    input aliasOp_e          op,
    input logic [DATA_W-1:0] mask
  );
    logic [DATA_W-1:0] r;
    case (op)
      OP_SET:  r = (oldVal | data) & mask;
      OP_CLR:  r = oldVal & ~data;
      default: r = data & mask;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strb,
  output rdSel_e            rdSel
);

  localparam int WORD_BITS  = 2;
  localparam int ALIAS_LSB  = 2;
  localparam int BLOCK_LSB  = 4;
  localparam int MAP_BITS   = 7;

  logic       inMap;
  logic       aligned;
  logic [1:0] aliasSel;
  logic [2:0] blockIdx;
  logic       accessOk;
  logic       wrOk;
  logic       fieldWr;
  logic       plainWr;

  assign inMap    = (addr >> MAP_BITS) == '0;
  assign aligned  = addr[WORD_BITS-1:0] == '0;
  assign aliasSel = addr[ALIAS_LSB+1:ALIAS_LSB];
  assign blockIdx = addr[BLOCK_LSB+2:BLOCK_LSB];
  assign accessOk = inMap && aligned;
  assign wrOk     = wrEn && accessOk;
  assign fieldWr  = wrOk && (aliasSel != 2'd3);
  assign plainWr  = wrOk && (aliasSel == 2'd0);

  always_comb begin
    rdSel = SEL_NONE;
    if (accessOk) begin
      case (blockIdx)
        3'd0:    rdSel = SEL_CTRL;
        3'd1:    rdSel = SEL_STAT;
        3'd3:    rdSel = SEL_SEC;
        3'd4:    rdSel = SEL_ALARM;
        3'd5:    rdSel = SEL_WDOG;
        3'd6:    rdSel = SEL_PERS0;
        3'd7:    rdSel = SEL_PERS1;
        default: rdSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.wrCtrl  = fieldWr && (blockIdx == 3'd0);
    strb.wrPers0 = fieldWr && (blockIdx == 3'd6);
    strb.wrPers1 = fieldWr && (blockIdx == 3'd7);
    strb.wrSec   = plainWr && (blockIdx == 3'd3);
    strb.wrAlarm = plainWr && (blockIdx == 3'd4);
    strb.wrWdog  = plainWr && (blockIdx == 3'd5);
    case (aliasSel)
      2'd1:    strb.op = OP_SET;
      2'd2:    strb.op = OP_CLR;
      default: strb.op = OP_WRITE;
    endcase
  end

  // R10: at most one register is targeted, and never without a bus write
  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrCtrl, strb.wrPers0, strb.wrPers1,
              strb.wrSec, strb.wrAlarm, strb.wrWdog}));

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> !(strb.wrCtrl || strb.wrPers0 || strb.wrPers1 ||
                strb.wrSec || strb.wrAlarm || strb.wrWdog));

  // R10: plain storage words only take base-address writes
  p_plain_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrSec || strb.wrAlarm || strb.wrWdog) |-> (addr[3:2] == 2'd0));

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobes_t       strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              secTick,
  input  logic              strapXtal32000,
  input  logic              strapXtal32768,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmFlag,
  output logic              alarmIrqEn
);

  logic [DATA_W-1:0] ctrlQ, pers0Q, pers1Q, secQ, alarmQ, wdogQ;
  logic [DATA_W-1:0] ctrlD, pers0D, pers1D, secD;
  logic [DATA_W-1:0] statusW;
  logic              alarmHit;

  assign alarmHit = secTick && pers0Q[P0_ALARM_EN] && (secQ == alarmQ);

  always_comb begin
    ctrlD = strb.wrCtrl ? applyAlias(ctrlQ, wrData, strb.op, CTRL_MASK) : ctrlQ;
    if (alarmHit) ctrlD[CTRL_FLAG] = 1'b1;
  end

  always_comb begin
    pers0D = strb.wrPers0 ? applyAlias(pers0Q, wrData, strb.op, PERS0_MASK) : pers0Q;
    if (alarmHit && pers0Q[P0_WAKE_EN]) pers0D[P0_WAKE_FLAG] = 1'b1;
  end

  assign pers1D = strb.wrPers1 ? applyAlias(pers1Q, wrData, strb.op, PERS1_MASK) : pers1Q;

  always_comb begin
    if (strb.wrSec)   secD = wrData;
    else if (secTick) secD = secQ + 1'b1;
    else              secD = secQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ  <= '0;
      pers0Q <= '0;
      pers1Q <= '0;
      secQ   <= '0;
      alarmQ <= '0;
      wdogQ  <= '0;
    end else begin
      ctrlQ  <= ctrlD;
      pers0Q <= pers0D;
      pers1Q <= pers1D;
      secQ   <= secD;
      if (strb.wrAlarm) alarmQ <= wrData;
      if (strb.wrWdog)  wdogQ  <= wrData;
    end
  end

  always_comb begin
    statusW               = '0;
    statusW[STAT_PRESENT] = 1'b1;
    statusW[STAT_X32000]  = strapXtal32000;
    statusW[STAT_X32768]  = strapXtal32768;
  end

  always_comb begin
    case (rdSel)
      SEL_CTRL:  rdData = ctrlQ;
      SEL_STAT:  rdData = statusW;
      SEL_SEC:   rdData = secQ;
      SEL_ALARM: rdData = alarmQ;
      SEL_WDOG:  rdData = wdogQ;
      SEL_PERS0: rdData = pers0Q;
      SEL_PERS1: rdData = pers1Q;
      default:   rdData = '0;
    endcase
  end

  assign alarmFlag  = ctrlQ[CTRL_FLAG];
  assign alarmIrqEn = ctrlQ[CTRL_IRQ_EN];

  // R3: a tick without a load advances the count by one, modulo 2^32
  p_tick_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (secTick && !strb.wrSec) |=> (secQ == $past(secQ) + 32'd1));

  // R3: a load wins over a tick
  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrSec |=> (secQ == $past(wrData)));

  // R5: unimplemented bits never hold a 1
  p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrlQ & ~CTRL_MASK) == '0) && ((pers0Q & ~PERS0_MASK) == '0) &&
    ((pers1Q & ~PERS1_MASK) == '0));

  // R6 and R9: a match leaves the flag set regardless of a same-cycle write
  p_hit_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alarmHit |=> ctrlQ[CTRL_FLAG]);

  // R6: without a write or a match, the flag does not rise
  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarmHit && !strb.wrCtrl && !ctrlQ[CTRL_FLAG]) |=> !ctrlQ[CTRL_FLAG]);

  // R7: wake flag follows a match when wake is enabled
  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarmHit && pers0Q[P0_WAKE_EN]) |=> pers0Q[P0_WAKE_FLAG]);

endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              secTick,
  input  logic              strapXtal32000,
  input  logic              strapXtal32768,
  output logic              alarmIrq
);

  regStrobes_t strb;
  rdSel_e      rdSel;
  logic        alarmFlag;
  logic        alarmIrqEn;

  rtc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wrEn  (wrEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  rtc_datapath uData (
    .clk            (clk),
    .rst_n          (rst_n),
    .strb           (strb),
    .rdSel          (rdSel),
    .wrData         (wrData),
    .secTick        (secTick),
    .strapXtal32000 (strapXtal32000),
    .strapXtal32768 (strapXtal32768),
    .rdData         (rdData),
    .alarmFlag      (alarmFlag),
    .alarmIrqEn     (alarmIrqEn)
  );

  assign alarmIrq = alarmFlag && alarmIrqEn;

  // R8: the pin is never high while the control enable is low
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alarmIrqEn |-> !alarmIrq);

endmodule

// File: tb/tb_rtc_alarm_regs.sv
module tb_rtc_alarm_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        secTick = 1'b0;
  logic        strapXtal32000 = 1'b0;
  logic        strapXtal32768 = 1'b0;
  logic        alarmIrq;

  int nCompared = 0;
  int nMismatched = 0;
  int cycles = 0;
  string lastReq = "R1";

  always #2 clk = ~clk;

  rtc_alarm_regs dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .secTick(secTick), .strapXtal32000(strapXtal32000),
    .strapXtal32768(strapXtal32768), .alarmIrq(alarmIrq)
  );

  // behavioural reference model
  logic [31:0] mCtrl, mP0, mP1, mSec, mAlarm, mWdog;

  always @(posedge clk) begin
    if (!rst_n) begin
      mCtrl = 0; mP0 = 0; mP1 = 0; mSec = 0; mAlarm = 0; mWdog = 0;
    end else begin
      bit match, wake, loaded;
      match  = secTick && mP0[2] && (mSec == mAlarm);
      wake   = mP0[1];
      loaded = 0;
      if (wrEn) begin
        case (addr)
          8'h00: mCtrl = wrData & 32'h17;
          8'h04: mCtrl = (mCtrl | wrData) & 32'h17;
          8'h08: mCtrl = mCtrl & ~wrData;
          8'h60: mP0 = wrData & 32'hF7;
          8'h64: mP0 = (mP0 | wrData) & 32'hF7;
          8'h68: mP0 = mP0 & ~wrData;
          8'h70: mP1 = wrData & 32'h8000_0000;
          8'h74: mP1 = (mP1 | wrData) & 32'h8000_0000;
          8'h78: mP1 = mP1 & ~wrData;
          8'h30: begin mSec = wrData; loaded = 1; end
          8'h40: mAlarm = wrData;
          8'h50: mWdog = wrData;
          default: ;
        endcase
      end
      if (secTick && !loaded) mSec = mSec + 1;
      if (match) mCtrl[2] = 1'b1;
      if (match && wake) mP0[7] = 1'b1;
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return mCtrl;
      8'h10, 8'h14, 8'h18, 8'h1C:
        return 32'h8000_0000 | (32'(strapXtal32000) << 28) | (32'(strapXtal32768) << 27);
      8'h30, 8'h34, 8'h38, 8'h3C: return mSec;
      8'h40, 8'h44, 8'h48, 8'h4C: return mAlarm;
      8'h50, 8'h54, 8'h58, 8'h5C: return mWdog;
      8'h60, 8'h64, 8'h68, 8'h6C: return mP0;
      8'h70, 8'h74, 8'h78, 8'h7C: return mP1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compareNow();
    logic [31:0] expRd;
    logic        expIrq;
    expRd  = modelRead(addr);
    expIrq = mCtrl[2] && mCtrl[0];
    nCompared++;
    if (rdData !== expRd) begin
      nMismatched++;
      $display("FAIL %s rdData addr=%h actual=%h expected=%h", lastReq, addr, rdData, expRd);
    end
    nCompared++;
    if (alarmIrq !== expIrq) begin
      nMismatched++;
      $display("FAIL %s alarmIrq actual=%b expected=%b", lastReq, alarmIrq, expIrq);
    end
  endtask

  // one bus cycle: check the previous cycle's outputs, then drive the next
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic t, input string req);
    @(negedge clk);
    if (rst_n) compareNow();
    lastReq = req;
    wrEn = we; addr = a; wrData = d; secTick = t;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(1'b0, a, 32'h0, 1'b0, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    step(1'b1, a, d, 1'b0, req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nMismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int i = 0; i < 32; i++) rd(8'(i * 4), "R1");

    // R2: status word with strap combinations, writes ignored
    rd(8'h10, "R2");
    strapXtal32000 = 1'b1;
    rd(8'h14, "R2");
    strapXtal32768 = 1'b1; strapXtal32000 = 1'b0;
    rd(8'h18, "R2");
    wr(8'h10, 32'hFFFF_FFFF, "R2");
    rd(8'h1C, "R2");

    // R4 and R5: replace, set and clear aliases with masking
    wr(8'h00, 32'hFFFF_FFFF, "R5"); rd(8'h00, "R5");
    wr(8'h08, 32'h0000_0005, "R4"); rd(8'h04, "R4");
    wr(8'h04, 32'h0000_0001, "R4"); rd(8'h0C, "R4");
    wr(8'h00, 32'h0, "R4");         rd(8'h00, "R4");
    wr(8'h60, 32'hFFFF_FFFF, "R5"); rd(8'h60, "R5");
    wr(8'h68, 32'h0000_0081, "R4"); rd(8'h64, "R4");
    wr(8'h64, 32'h0000_0100, "R5"); rd(8'h60, "R5");
    wr(8'h60, 32'h0, "R4");
    wr(8'h74, 32'hFFFF_FFFF, "R5"); rd(8'h70, "R5");
    wr(8'h78, 32'h8000_0000, "R4"); rd(8'h7C, "R4");
    wr(8'h70, 32'h8000_0001, "R4"); rd(8'h70, "R4");

    // R3: ticks, wrap, load wins over a tick
    wr(8'h30, 32'hFFFF_FFFE, "R3");
    step(1'b0, 8'h30, 0, 1'b1, "R3");
    step(1'b0, 8'h30, 0, 1'b1, "R3");
    step(1'b0, 8'h30, 0, 1'b1, "R3");
    rd(8'h30, "R3");
    step(1'b1, 8'h30, 32'h0000_0005, 1'b1, "R3");
    rd(8'h30, "R3");
    wr(8'h50, 32'h1234_5678, "R3"); rd(8'h50, "R3");

    // R6: no match while the alarm enable is low
    wr(8'h40, 32'h0000_0007, "R6");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 0, 1'b1, "R6");
    rd(8'h00, "R6");

    // R6, R7, R8: armed match sets flag, wake flag, interrupt
    wr(8'h30, 32'h0000_0005, "R6");
    wr(8'h64, 32'h0000_0006, "R7");
    wr(8'h04, 32'h0000_0001, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 0, 1'b1, "R6");
    rd(8'h60, "R7");
    rd(8'h00, "R8");
    wr(8'h08, 32'h0000_0001, "R8"); rd(8'h00, "R8");
    wr(8'h04, 32'h0000_0001, "R8"); rd(8'h00, "R8");
    wr(8'h08, 32'h0000_0004, "R8"); rd(8'h00, "R8");

    // R9: clear of flag and wake flag coincides with a matching tick
    wr(8'h30, 32'h0000_0007, "R9");
    step(1'b1, 8'h08, 32'h0000_0004, 1'b1, "R9");
    rd(8'h00, "R9");
    wr(8'h30, 32'h0000_0007, "R9");
    step(1'b1, 8'h68, 32'h0000_0080, 1'b1, "R9");
    rd(8'h60, "R9");
    wr(8'h30, 32'h0000_0007, "R9");
    step(1'b1, 8'h00, 32'h0000_0000, 1'b1, "R9");
    rd(8'h00, "R9");

    // R10: ignored writes and unmapped reads
    wr(8'h0C, 32'h0, "R10");           rd(8'h00, "R10");
    wr(8'h6C, 32'h0, "R10");           rd(8'h60, "R10");
    wr(8'h34, 32'hFFFF_FFFF, "R10");   rd(8'h30, "R10");
    wr(8'h48, 32'h0, "R10");           rd(8'h40, "R10");
    wr(8'h54, 32'h0, "R10");           rd(8'h50, "R10");
    wr(8'h01, 32'h0, "R10");           rd(8'h00, "R10");
    wr(8'h20, 32'hFFFF_FFFF, "R10");   rd(8'h20, "R10");
    wr(8'h80, 32'h0, "R10");           rd(8'h80, "R10");
    rd(8'h31, "R10");
    rd(8'hE0, "R10");
    rd(8'h00, "R10");

    @(negedge clk);
    compareNow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule